// File: doc/BRIEF.md
# Byte Shift and Rotate Unit with Carry Flag

This unit performs one of eight shift or rotate operations on a data byte and returns the new byte together with an updated carry flag. The flags follow the usual processor conventions. A caller places an operand, a 3-bit operation code and a count source on the inputs, then raises `start_i` for one cycle. On the next clock edge the unit registers the result and the carry, and `done_o` pulses for that one cycle.

The count can come from an immediate input. It can also come from a count register inside the unit, which is loaded through its own write strobe. Only the low five bits of whichever count is chosen are used. The carry flag is kept inside the unit. It takes part in the two rotate-through-carry operations as a ninth bit.

Top module: `shrot_unit`

## Requirements
- R1: After reset, `result_o` is 0x00, `carry_o` is 0, `done_o` is 0 and the count register holds 0.
- R2: `result_o` and `carry_o` change only on the clock edge that samples `start_i` high. `done_o` is high in exactly the cycle after each such edge. Without a start, the outputs hold their values.
- R3: `cnt_src_i`=0 takes the count from `cnt_imm_i`, and `cnt_src_i`=1 takes it from the count register. `cnt_wr_i` loads `cnt_wdata_i` into the count register on the clock edge. A start in the same cycle still uses the old register value. Both sources are masked to their low 5 bits, so the count ranges from 0 to 31.
- R4: A masked count of 0 returns the operand unchanged and leaves the carry flag as it was, for every operation code.
- R5: Code 0 is logical left shift and code 1 is logical right shift. Vacated positions fill with 0, and the carry becomes the last bit moved out. A count above 8 gives 0x00 with carry 0.
- R6: Code 2 is arithmetic left shift. It gives exactly the result and carry of code 0.
- R7: Code 3 is arithmetic right shift. The sign bit fills the vacated positions and the carry is the last bit moved out, so 0xFF by 1 gives 0xFF with carry 1. A count of 8 or more gives all sign bits with carry equal to the sign.
- R8: Code 4 is rotate left and code 5 is rotate right. The byte rotates by the count modulo 8. The carry is the bit that lands at the wrap end: bit 0 for a left rotate, bit 7 for a right rotate. Nonzero multiples of 8 return the operand with that carry.
- R9: Code 6 rotates left and code 7 rotates right through carry. Both treat {carry, operand} as a 9-bit value rotated by the count modulo 9, with the carry at the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Perform one operation |
| op_i | input | 3 | Operation code (R5 to R9) |
| operand_i | input | 8 | Data byte |
| cnt_src_i | input | 1 | Count source: 0 immediate, 1 count register |
| cnt_imm_i | input | 8 | Immediate count (low 5 bits used) |
| cnt_wr_i | input | 1 | Load the count register |
| cnt_wdata_i | input | 8 | Value for the count register |
| result_o | output | 8 | Registered result byte |
| carry_o | output | 1 | Registered carry flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every result is due one clock edge after the start is sampled. The bench drives inputs on the falling edge, drops `start_i` on the next falling edge, and reads `result_o`, `carry_o` and `done_o` at that same falling edge. It then confirms one falling edge later that `done_o` has dropped. A count-register write takes effect on the same edge as a start that shares its cycle, so the bench updates its model of the count register only after it has computed the expected result for that start. During idle stretches with changing operands, the bench checks that the held outputs stay unchanged. The expected value comes from a bit-by-bit stepping model that needs no modulo arithmetic.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    // Operation codes; bit 2 selects the rotator, bit 0 selects right
    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_SAL = 3'd2,
        OP_SAR = 3'd3,
        OP_ROL = 3'd4,
        OP_ROR = 3'd5,
        OP_RCL = 3'd6,
        OP_RCR = 3'd7
    } shrot_op_e;

    function automatic logic is_rotate(input logic [2:0] op);
        return op[2];
    endfunction

endpackage

// File: rtl/shrot_cnt_sel.sv
module shrot_cnt_sel #(
    parameter int unsigned CREG_W = 8,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              src_i,
    input  logic [CREG_W-1:0] imm_i,
    input  logic [CREG_W-1:0] reg_i,
    output logic [CNT_W-1:0]  cnt_o
);
    logic [CREG_W-1:0] raw;

    always_comb begin
        raw   = src_i ? reg_i : imm_i;
        cnt_o = CNT_W'(raw);
    end
endmodule

// File: rtl/shrot_shifter.sv
module shrot_shifter #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 5
) (
    input  logic [1:0]        mode_i,   // 00 left, 01 right, 10 left, 11 arith right
    input  logic [DATA_W-1:0] a_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cf_o
);
    localparam int unsigned EXT_W = DATA_W + (1 << CNT_W) + 1;

    logic [DATA_W:0]        left_v;
    logic [DATA_W:0]        lright_v;
    logic [DATA_W:0]        aright_v;
    logic signed [EXT_W-1:0] sgn_src;

    always_comb begin
        // left: carry is the bit that crosses position DATA_W
        left_v   = (DATA_W + 1)'(EXT_W'(a_i) << cnt_i);
        // right: a guard bit below bit 0 catches the last bit out
        lright_v = (DATA_W + 1)'(EXT_W'({a_i, 1'b0}) >> cnt_i);
        sgn_src  = {{(EXT_W - DATA_W - 1){a_i[DATA_W-1]}}, a_i, 1'b0};
        aright_v = (DATA_W + 1)'(sgn_src >>> cnt_i);

        if (!mode_i[0]) begin
            res_o = left_v[DATA_W-1:0];
            cf_o  = left_v[DATA_W];
        end else if (mode_i[1]) begin
            res_o = aright_v[DATA_W:1];
            cf_o  = aright_v[0];
        end else begin
            res_o = lright_v[DATA_W:1];
            cf_o  = lright_v[0];
        end
    end
endmodule

// File: rtl/shrot_rotator.sv
module shrot_rotator #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 5
) (
    input  logic [1:0]        mode_i,   // bit0 right, bit1 through carry
    input  logic [DATA_W-1:0] a_i,
    input  logic              cf_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cf_o
);
    localparam int unsigned RING_W = DATA_W + 1;

    logic [CNT_W-1:0]    amt_byte;
    logic [CNT_W-1:0]    amt_ring;
    logic [2*DATA_W-1:0] dbl_byte;
    logic [2*RING_W-1:0] dbl_ring;
    logic [DATA_W-1:0]   byte_res;
    logic [RING_W-1:0]   ring_res;

    always_comb begin
        amt_byte = CNT_W'(32'(cnt_i) % DATA_W);
        amt_ring = CNT_W'(32'(cnt_i) % RING_W);
        dbl_byte = {a_i, a_i};
        dbl_ring = {cf_i, a_i, cf_i, a_i};

        if (mode_i[0]) begin
            byte_res = DATA_W'(dbl_byte >> amt_byte);
            ring_res = RING_W'(dbl_ring >> amt_ring);
        end else begin
            byte_res = DATA_W'((dbl_byte << amt_byte) >> DATA_W);
            ring_res = RING_W'((dbl_ring << amt_ring) >> RING_W);
        end

        if (mode_i[1]) begin
            res_o = ring_res[DATA_W-1:0];
            cf_o  = ring_res[DATA_W];
        end else begin
            res_o = byte_res;
            cf_o  = mode_i[0] ? byte_res[DATA_W-1] : byte_res[0];
        end
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 5,
    parameter int unsigned CREG_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              cnt_src_i,
    input  logic [CREG_W-1:0] cnt_imm_i,
    input  logic              cnt_wr_i,
    input  logic [CREG_W-1:0] cnt_wdata_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              done_o
);
    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              carry;
        logic              done;
        logic [CREG_W-1:0] creg;
    } state_t;

    state_t st_d, st_q;

    logic [CREG_W-1:0] creg_q;
    logic [CNT_W-1:0]  eff_cnt;
    logic [DATA_W-1:0] sh_res, rt_res;
    logic              sh_cf, rt_cf;

    assign creg_q = st_q.creg;

    shrot_cnt_sel #(.CREG_W(CREG_W), .CNT_W(CNT_W)) u_cnt_sel (
        .src_i (cnt_src_i),
        .imm_i (cnt_imm_i),
        .reg_i (creg_q),
        .cnt_o (eff_cnt)
    );

    shrot_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shifter (
        .mode_i (op_i[1:0]),
        .a_i    (operand_i),
        .cnt_i  (eff_cnt),
        .res_o  (sh_res),
        .cf_o   (sh_cf)
    );

    shrot_rotator #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rotator (
        .mode_i (op_i[1:0]),
        .a_i    (operand_i),
        .cf_i   (st_q.carry),
        .cnt_i  (eff_cnt),
        .res_o  (rt_res),
        .cf_o   (rt_cf)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.done = 1'b1;
            if (eff_cnt == '0) begin
                st_d.result = operand_i;
            end else if (is_rotate(op_i)) begin
                st_d.result = rt_res;
                st_d.carry  = rt_cf;
            end else begin
                st_d.result = sh_res;
                st_d.carry  = sh_cf;
            end
        end
        if (cnt_wr_i) begin
            st_d.creg = cnt_wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign carry_o  = st_q.carry;
    assign done_o   = st_q.done;
endmodule

// File: rtl/shrot_chk.sv
module shrot_chk
    import shrot_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 5,
    parameter int unsigned CREG_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [2:0]        op_i,
    input logic [DATA_W-1:0] operand_i,
    input logic              cnt_src_i,
    input logic [CREG_W-1:0] cnt_imm_i,
    input logic              cnt_wr_i,
    input logic [CREG_W-1:0] cnt_wdata_i,
    input logic [CREG_W-1:0] creg_q,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_o,
    input logic              done_o
);
    logic [CNT_W-1:0] eff;
    assign eff = cnt_src_i ? CNT_W'(creg_q) : CNT_W'(cnt_imm_i);

    assert_done_after_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> done_o);
    assert_done_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> !done_o);
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> $stable(result_o) && $stable(carry_o));
    assert_creg_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr_i |=> creg_q == $past(cnt_wdata_i));
    assert_zero_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && eff == '0 |=> result_o == $past(operand_i) && $stable(carry_o));
    assert_left_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && (op_i == OP_SHL || op_i == OP_SAL) && eff == CNT_W'(1)
        |=> result_o == {$past(operand_i[DATA_W-2:0]), 1'b0} && carry_o == $past(operand_i[DATA_W-1]));
    assert_sign_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && op_i == OP_SAR |=> result_o[DATA_W-1] == $past(operand_i[DATA_W-1]));
    assert_rot_ones_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && (op_i == OP_ROL || op_i == OP_ROR)
        |=> $countones(result_o) == $countones($past(operand_i)));
    assert_ring_ones_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && (op_i == OP_RCL || op_i == OP_RCR)
        |=> $countones({carry_o, result_o}) == $countones({$past(carry_o), $past(operand_i)}));
endmodule

bind shrot_unit shrot_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CREG_W(CREG_W)) u_shrot_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .op_i        (op_i),
    .operand_i   (operand_i),
    .cnt_src_i   (cnt_src_i),
    .cnt_imm_i   (cnt_imm_i),
    .cnt_wr_i    (cnt_wr_i),
    .cnt_wdata_i (cnt_wdata_i),
    .creg_q      (creg_q),
    .result_o    (result_o),
    .carry_o     (carry_o),
    .done_o      (done_o)
);

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] op = '0;
    logic [7:0] operand = '0;
    logic       src = 1'b0;
    logic [7:0] imm = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] result;
    logic       carry;
    logic       done;

    int checks = 0;
    int errors = 0;
    logic       m_cf = 1'b0;
    logic [7:0] m_creg = '0;

    always #5 clk = ~clk;

    shrot_unit u_shrot_unit (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .operand_i(operand),
        .cnt_src_i(src), .cnt_imm_i(imm), .cnt_wr_i(wr), .cnt_wdata_i(wdata),
        .result_o(result), .carry_o(carry), .done_o(done)
    );

    // step-by-step model: one single-bit move per count step
    function automatic logic [8:0] model(input logic [2:0] o, input logic [7:0] a,
                                         input logic cf, input int n);
        logic [7:0] v = a;
        logic       c = cf;
        logic       t;
        for (int i = 0; i < n; i++) begin
            case (o)
                3'd0, 3'd2: begin c = v[7]; v = {v[6:0], 1'b0}; end
                3'd1:       begin c = v[0]; v = {1'b0, v[7:1]}; end
                3'd3:       begin c = v[0]; v = {v[7], v[7:1]}; end
                3'd4:       begin v = {v[6:0], v[7]}; c = v[0]; end
                3'd5:       begin v = {v[0], v[7:1]}; c = v[7]; end
                3'd6:       begin t = v[7]; v = {v[6:0], c}; c = t; end
                default:    begin t = v[0]; v = {c, v[7:1]}; c = t; end
            endcase
        end
        return {c, v};
    endfunction

    function automatic string tag_of(input logic [2:0] o, input int n);
        if (n == 0) return "R4";
        case (o)
            3'd0, 3'd1: return "R5";
            3'd2:       return "R6";
            3'd3:       return "R7";
            3'd4, 3'd5: return "R8";
            default:    return "R9";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic [7:0] a, input logic s,
                          input logic [7:0] i, input logic w, input logic [7:0] wd,
                          input string extra);
        int         n;
        logic [8:0] e;
        string      t;
        @(negedge clk);
        op = o; operand = a; src = s; imm = i; wr = w; wdata = wd; start = 1'b1;
        n = int'((s ? m_creg : i) & 8'h1F);
        e = model(o, a, m_cf, n);
        t = (extra != "") ? extra : tag_of(o, n);
        @(negedge clk);
        start = 1'b0; wr = 1'b0;
        check(done === 1'b1, "R2 done", int'(done), 1);
        check(result === e[7:0], t, int'(result), int'(e[7:0]));
        check(carry === e[8], t, int'(carry), int'(e[8]));
        m_cf = e[8];
        if (w) m_creg = wd;
        @(negedge clk);
        check(done === 1'b0, "R2 pulse", int'(done), 0);
    endtask

    task automatic idle_hold(input int cycles);
        logic [7:0] r0 = result;
        logic       c0 = carry;
        for (int k = 0; k < cycles; k++) begin
            operand = 8'($urandom); op = 3'($urandom); imm = 8'($urandom);
            @(negedge clk);
            check(result === r0 && carry === c0 && done === 1'b0, "R2 hold",
                  int'({carry, result}), int'({c0, r0}));
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(result === 8'h00, "R1 result", int'(result), 0);
        check(carry === 1'b0, "R1 carry", int'(carry), 0);
        check(done === 1'b0, "R1 done", int'(done), 0);
        // count register resets to 0: count-from-register op leaves operand
        run_op(3'd0, 8'h5A, 1'b1, 8'h00, 1'b0, 8'h00, "R1 creg");

        // logical shifts (R5), count from immediate
        run_op(3'd0, 8'h81, 1'b0, 8'd1, 1'b0, 8'h00, "R5");   // 0x02 c1
        run_op(3'd0, 8'h02, 1'b0, 8'd1, 1'b0, 8'h00, "R5");   // 0x04 c0
        run_op(3'd1, 8'h04, 1'b0, 8'd1, 1'b0, 8'h00, "R5");   // 0x02 c0
        run_op(3'd0, 8'h02, 1'b0, 8'd2, 1'b0, 8'h00, "R5");   // 0x08
        // count from register (R3): 2
        run_op(3'd0, 8'h00, 1'b0, 8'd0, 1'b1, 8'd2, "R3 wr");
        run_op(3'd0, 8'h08, 1'b1, 8'd0, 1'b0, 8'h00, "R3 reg"); // 0x20 c0
        run_op(3'd0, 8'hFF, 1'b0, 8'd9, 1'b0, 8'h00, "R5 big");
        run_op(3'd1, 8'hFF, 1'b0, 8'd8, 1'b0, 8'h00, "R5 eight");
        // masking (R3): 0x21 -> 1
        run_op(3'd1, 8'h03, 1'b0, 8'h21, 1'b0, 8'h00, "R3 mask");
        // R6
        run_op(3'd2, 8'hFF, 1'b0, 8'd1, 1'b0, 8'h00, "R6");   // 0xFE c1
        // R7
        run_op(3'd3, 8'hFE, 1'b0, 8'd1, 1'b0, 8'h00, "R7");   // 0xFF c0
        run_op(3'd3, 8'hFF, 1'b0, 8'd1, 1'b0, 8'h00, "R7");   // 0xFF c1
        run_op(3'd3, 8'h80, 1'b0, 8'd20, 1'b0, 8'h00, "R7 big");
        // R8
        run_op(3'd4, 8'h81, 1'b0, 8'd1, 1'b0, 8'h00, "R8");   // 0x03 c1
        run_op(3'd5, 8'h06, 1'b0, 8'd2, 1'b0, 8'h00, "R8");   // 0x81 c1
        run_op(3'd5, 8'h81, 1'b0, 8'd1, 1'b0, 8'h00, "R8");   // 0xC0 c1
        run_op(3'd4, 8'h82, 1'b0, 8'd16, 1'b0, 8'h00, "R8 wrap");
        // R9: clear carry then run the 9-bit sequence
        run_op(3'd0, 8'h00, 1'b0, 8'd1, 1'b0, 8'h00, "R5 clr");
        run_op(3'd6, 8'h81, 1'b0, 8'd1, 1'b0, 8'h00, "R9");   // 0x02 c1
        run_op(3'd6, 8'h02, 1'b0, 8'd1, 1'b0, 8'h00, "R9");   // 0x05 c0
        run_op(3'd7, 8'h05, 1'b0, 8'd2, 1'b0, 8'h00, "R9");   // 0x81 c0
        run_op(3'd7, 8'h81, 1'b0, 8'd1, 1'b0, 8'h00, "R9");   // 0x40 c1
        run_op(3'd6, 8'h3C, 1'b0, 8'd9, 1'b0, 8'h00, "R9 mod9");
        run_op(3'd7, 8'hA5, 1'b0, 8'd31, 1'b0, 8'h00, "R9 max");
        // R4: zero count with carry set keeps both
        run_op(3'd0, 8'h80, 1'b0, 8'd1, 1'b0, 8'h00, "R5 set");
        for (int oc = 0; oc < 8; oc++)
            run_op(3'(oc), 8'h3E, 1'b0, 8'h20, 1'b0, 8'h00, "R4");
        // R3: write and start in the same cycle uses the old register value
        run_op(3'd0, 8'h00, 1'b0, 8'd0, 1'b1, 8'd1, "R3 wr");
        run_op(3'd0, 8'h11, 1'b1, 8'd0, 1'b1, 8'd3, "R3 same");
        run_op(3'd0, 8'h11, 1'b1, 8'd0, 1'b0, 8'd0, "R3 new");
        // R2: held outputs while idle
        idle_hold(4);

        for (int k = 0; k < 400; k++) begin
            run_op(3'($urandom), 8'($urandom), 1'($urandom), 8'($urandom),
                   ($urandom % 4) == 0, 8'($urandom), "");
            if (k % 50 == 0) idle_hold(2);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule